// File: doc/BRIEF.md
# Holdover Frequency Word Generator

This block produces the frequency control word that drives a digital PLL's oscillator while the loop is in holdover. When the loop is not in holdover, the live loop frequency word passes straight through. When holdover is active, the output comes from one of three sources, picked by configuration inputs:

- a software-supplied word, in manual holdover;
- a frozen copy of the integral-path word, in automatic instantaneous holdover;
- a slow single-pole IIR average of the loop frequency word, in automatic averaged holdover.

The frozen copy excludes the proportional term, so recent phase hits barely move it. The averager runs on a slow sample strobe while the loop is locked. Its time constant can be switched between a fast setting and a slow setting. It stops updating once holdover begins, so the averaged output stays constant.

All frequency words are two's-complement signed. The averager keeps `FRAC_W` extra fractional bits. Its output is the integer part, rounded toward minus infinity.

Top module: `holdover_freq_gen`

## Requirements
- R1: After reset the averager and the freeze register both hold zero. Entering averaged holdover before any qualified sample gives freq_o = 0.
- R2: While holdover_i is low, freq_o equals freq_i in the same cycle.
- R3: While holdover_i and manual_i are both high, freq_o equals sw_freq_i, whatever auto_avg_i is.
- R4: With holdover_i high, manual_i low and auto_avg_i low, freq_o equals the integ_i value present at the last rising clock edge at which holdover_i was low. Later changes of integ_i have no effect on it.
- R5: With holdover_i high, manual_i low and auto_avg_i high, freq_o equals floor(acc / 2^FRAC_W), where acc is the averager state.
- R6: A qualified sample updates the state as acc += ((x·2^FRAC_W) − acc) >>> k, where x is freq_i. k is K_FAST (default 4) when fast_avg_i is high and K_SLOW (default 8) when it is low.
- R7: A sample is qualified only at a rising edge where sample_i = 1, locked_i = 1 and holdover_i = 0. At any other edge the averager keeps its value.
- R8: The first qualified sample after reset loads acc = x·2^FRAC_W directly, with no filtering.
- R9: Negative words are handled with arithmetic shifts. For example, after a first sample of −1000 followed by a sample of −999 with k = 4, the averaged output is −1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| holdover_i | input | 1 | Loop is in holdover |
| locked_i | input | 1 | Loop is phase locked |
| sample_i | input | 1 | Averager sample strobe |
| manual_i | input | 1 | 1 = manual holdover word, 0 = automatic |
| auto_avg_i | input | 1 | In automatic mode: 1 = averaged, 0 = instantaneous |
| fast_avg_i | input | 1 | 1 = fast time constant, 0 = slow |
| integ_i | input | W | Loop integral-path word (signed) |
| freq_i | input | W | Live loop frequency word (signed) |
| sw_freq_i | input | W | Software holdover word (signed) |
| freq_o | output | W | Frequency word to apply (signed) |

## Verification
The hold properties assume that the mode inputs stay fixed for at least two edges inside a holdover interval. Only under that condition is a stable output expected. The stimulus changes mode only at sequence boundaries and spends several cycles in each mode. The averager-hold property assumes that sample_i, locked_i and holdover_i are synchronous levels sampled at the edge. The bench drives every input shortly after the rising edge, so all of them are settled when sampled.

// File: rtl/hfg_pkg.sv
package hfg_pkg;
  typedef enum logic [1:0] {
    SRC_LIVE   = 2'd0,
    SRC_MANUAL = 2'd1,
    SRC_AVG    = 2'd2,
    SRC_FROZEN = 2'd3
  } src_e;

  function automatic src_e pick_src(logic hold, logic man, logic avg);
    if (!hold)    return SRC_LIVE;
    else if (man) return SRC_MANUAL;
    else if (avg) return SRC_AVG;
    else          return SRC_FROZEN;
  endfunction
endpackage

// File: rtl/hfg_iir.sv
module hfg_iir #(
  parameter int W      = 24,
  parameter int FRAC_W = 16,
  parameter int K_FAST = 4,
  parameter int K_SLOW = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic         fast_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] avg_o
);
  localparam int AW = W + FRAC_W;

  logic signed [AW-1:0] acc_q, acc_d;
  logic                 primed_q;
  logic signed [AW:0]   x_ext, acc_ext, diff, step, nxt;

  always_comb begin
    x_ext   = {x_i[W-1], x_i, {FRAC_W{1'b0}}};
    acc_ext = {acc_q[AW-1], acc_q};
    diff    = x_ext - acc_ext;
    step    = fast_i ? (diff >>> K_FAST) : (diff >>> K_SLOW);
    nxt     = primed_q ? (acc_ext + step) : x_ext;  // first sample seeds directly
    acc_d   = nxt[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      primed_q <= 1'b0;
    end else if (upd_i) begin
      acc_q    <= acc_d;
      primed_q <= 1'b1;
    end
  end

  assign avg_o = acc_q[FRAC_W +: W];
endmodule

// File: rtl/hfg_freeze.sv
module hfg_freeze #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [W-1:0] integ_i,
  output logic [W-1:0] frz_o
);
  logic [W-1:0] frz_q;

  // tracks until holdover, then holds the last pre-holdover value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frz_q <= '0;
    else if (!hold_i) frz_q <= integ_i;
  end

  assign frz_o = frz_q;
endmodule

// File: rtl/hfg_sel.sv
module hfg_sel
  import hfg_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         hold_i,
  input  logic         man_i,
  input  logic         avg_en_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] sw_i,
  input  logic [W-1:0] avg_i,
  input  logic [W-1:0] frz_i,
  output logic [W-1:0] out_o
);
  src_e src;

  always_comb begin
    src = pick_src(hold_i, man_i, avg_en_i);
    unique case (src)
      SRC_LIVE:   out_o = live_i;
      SRC_MANUAL: out_o = sw_i;
      SRC_AVG:    out_o = avg_i;
      default:    out_o = frz_i;
    endcase
  end
endmodule

// File: rtl/holdover_freq_gen.sv
module holdover_freq_gen #(
  parameter int W      = 24,
  parameter int FRAC_W = 16,
  parameter int K_FAST = 4,
  parameter int K_SLOW = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         holdover_i,
  input  logic         locked_i,
  input  logic         sample_i,
  input  logic         manual_i,
  input  logic         auto_avg_i,
  input  logic         fast_avg_i,
  input  logic [W-1:0] integ_i,
  input  logic [W-1:0] freq_i,
  input  logic [W-1:0] sw_freq_i,
  output logic [W-1:0] freq_o
);
  logic         upd_w;
  logic [W-1:0] avg_w, frz_w;

  assign upd_w = sample_i & locked_i & ~holdover_i;

  hfg_iir #(.W(W), .FRAC_W(FRAC_W), .K_FAST(K_FAST), .K_SLOW(K_SLOW)) u_iir (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (upd_w),
    .fast_i(fast_avg_i),
    .x_i   (freq_i),
    .avg_o (avg_w)
  );

  hfg_freeze #(.W(W)) u_frz (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (holdover_i),
    .integ_i(integ_i),
    .frz_o  (frz_w)
  );

  hfg_sel #(.W(W)) u_sel (
    .hold_i  (holdover_i),
    .man_i   (manual_i),
    .avg_en_i(auto_avg_i),
    .live_i  (freq_i),
    .sw_i    (sw_freq_i),
    .avg_i   (avg_w),
    .frz_i   (frz_w),
    .out_o   (freq_o)
  );
endmodule

// File: rtl/hfg_chk.sv
module hfg_chk #(
  parameter int W = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         holdover_i,
  input logic         locked_i,
  input logic         sample_i,
  input logic         manual_i,
  input logic         auto_avg_i,
  input logic [W-1:0] freq_i,
  input logic [W-1:0] sw_freq_i,
  input logic [W-1:0] freq_o,
  input logic [W-1:0] avg_i
);
  // R2
  live_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !holdover_i |-> freq_o == freq_i);

  // R3
  manual_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (holdover_i && manual_i) |-> freq_o == sw_freq_i);

  // R4
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (holdover_i && !manual_i && !auto_avg_i) |=>
      ((holdover_i && !manual_i && !auto_avg_i) -> $stable(freq_o)));

  // R5
  avg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (holdover_i && !manual_i && auto_avg_i) |=>
      ((holdover_i && !manual_i && auto_avg_i) -> $stable(freq_o)));

  // R7
  avg_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_i && locked_i && !holdover_i) |=> $stable(avg_i));
endmodule

bind holdover_freq_gen hfg_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .holdover_i(holdover_i),
  .locked_i  (locked_i),
  .sample_i  (sample_i),
  .manual_i  (manual_i),
  .auto_avg_i(auto_avg_i),
  .freq_i    (freq_i),
  .sw_freq_i (sw_freq_i),
  .freq_o    (freq_o),
  .avg_i     (avg_w)
);

// File: tb/sim_holdover_freq_gen.sv
`timescale 1ns/1ps
module sim_holdover_freq_gen;
  localparam int W = 24, FRAC_W = 16, K_FAST = 4, K_SLOW = 8;

  logic clk = 0, rst_ni = 0;
  logic holdover = 0, locked = 0, sample = 0, manual = 0, auto_avg = 0, fast = 0;
  logic [W-1:0] integ = '0, freq = '0, sw = '0, freq_o;

  int n_chk = 0, n_bad = 0;
  longint m_acc = 0, m_frz = 0;
  bit m_primed = 0;

  always #5 clk = ~clk;

  holdover_freq_gen #(.W(W), .FRAC_W(FRAC_W), .K_FAST(K_FAST), .K_SLOW(K_SLOW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .holdover_i(holdover), .locked_i(locked),
    .sample_i(sample), .manual_i(manual), .auto_avg_i(auto_avg), .fast_avg_i(fast),
    .integ_i(integ), .freq_i(freq), .sw_freq_i(sw), .freq_o(freq_o));

  function automatic longint sx(logic [W-1:0] v);
    return longint'(signed'(v));
  endfunction

  // reference model state
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_acc = 0; m_frz = 0; m_primed = 0;
    end else begin
      if (!holdover) m_frz = sx(integ);
      if (sample && locked && !holdover) begin
        longint xs;
        xs = sx(freq) * (longint'(1) << FRAC_W);
        if (!m_primed) m_acc = xs;
        else m_acc = m_acc + ((xs - m_acc) >>> (fast ? K_FAST : K_SLOW));
        m_primed = 1;
      end
    end
  end

  function automatic longint expect_out();
    if (!holdover) return sx(freq);
    if (manual)    return sx(sw);
    if (auto_avg)  return m_acc >>> FRAC_W;
    return m_frz;
  endfunction

  task automatic check(string tag);
    longint e;
    e = expect_out();
    n_chk++;
    if (sx(freq_o) != e) begin
      n_bad++;
      $display("FAIL %s: freq_o=%0d expected=%0d at %0t", tag, sx(freq_o), e, $time);
    end
  endtask

  // compare every clock, away from the edge
  always @(negedge clk) if (rst_ni) begin
    if (!holdover)     check("R2");
    else if (manual)   check("R3");
    else if (auto_avg) check("R5");
    else               check("R4");
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic smp(int x);
    freq = W'(x); sample = 1; tick(); sample = 0;
  endtask

  task automatic directed(string tag, longint e);
    @(negedge clk);
    n_chk++;
    if (sx(freq_o) != e) begin
      n_bad++;
      $display("FAIL %s: freq_o=%0d expected=%0d", tag, sx(freq_o), e);
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: expired, actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick(3); rst_ni = 1; tick();
    // R1: averaged holdover before any sample
    holdover = 1; auto_avg = 1; tick(2);
    directed("R1", 0);
    holdover = 0; auto_avg = 0; tick();

    // R2: live pass-through with varied words
    for (int i = 0; i < 8; i++) begin freq = W'(i * 12345 - 40000); tick(); end

    // R8: first qualified sample seeds directly
    locked = 1; fast = 1; smp(1000);
    holdover = 1; auto_avg = 1; tick(2);
    directed("R8", 1000);
    holdover = 0; tick();

    // R6: fast step 1000 -> 2000, expect 1062
    smp(2000);
    holdover = 1; tick(2);
    directed("R6", 1062);
    holdover = 0; tick();

    // R6: slow step
    fast = 0; smp(2000); smp(2000);
    holdover = 1; tick(2); directed("R6", m_acc >>> FRAC_W);
    holdover = 0; tick();

    // R7: strobe without lock, and strobe during holdover, ignored
    begin
      longint keep;
      keep = m_acc >>> FRAC_W;
      locked = 0; smp(500000); smp(500000);
      locked = 1; holdover = 1; smp(-500000); tick(2);
      directed("R7", keep);
      holdover = 0; tick();
    end

    // random-ish sample run, fast and slow mixed
    for (int i = 0; i < 60; i++) begin
      fast = i[2];
      smp((i * 7919) % 300000 - 150000);
      tick(i % 3);
    end
    holdover = 1; tick(5); holdover = 0; tick();

    // R4: freeze captures integ before holdover; later changes ignored
    auto_avg = 0; integ = W'(-77777); tick();
    integ = W'(4242); tick();
    holdover = 1; integ = W'(999); tick(); integ = W'(-5); tick(2);
    directed("R4", 4242);
    holdover = 0; tick(2);

    // R3: manual, both averaging settings
    sw = W'(-123456); manual = 1; holdover = 1; auto_avg = 1; tick(2);
    directed("R3", -123456);
    auto_avg = 0; sw = W'(654321); tick(2);
    directed("R3", 654321);
    manual = 0; holdover = 0; tick();

    // R9: negative words with arithmetic shift
    rst_ni = 0; tick(); rst_ni = 1; tick();
    fast = 1; locked = 1; auto_avg = 1;
    smp(-1000); smp(-999);
    holdover = 1; tick(2);
    directed("R9", -1000);
    holdover = 0; tick();
    for (int i = 0; i < 20; i++) smp(-200000 + i * 900);
    holdover = 1; tick(3); directed("R9", m_acc >>> FRAC_W);
    holdover = 0; tick(3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule